// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock for a shift engine from a fast module clock. A single configuration word carries two divisor fields. One is a linear divisor that divides by twice its value plus one. The other is an exponent that divides by a power of two. A mode bit chooses which of the two is in force. The block emits a one-cycle half-period tick, flags telling the shift engine whether that tick is a rising or a falling serial-clock edge, and a registered divided clock for observation.

Control is a two-state machine. In `ST_IDLE` the counter and the divided clock are held at zero. The transition IDLE->RUN is taken on any edge where `enable` is high and no configuration write is present. In `ST_RUN` the counter advances and wraps at the selected half-period. The RUN->RUN transition covers both counting and wrapping. The transition RUN->IDLE is taken on any edge with a configuration write or with `enable` low. As a result, every write and every rising `enable` restarts the divider from a known phase.

Top module: `sclk_dual_divider`

## Requirements
- R1: After reset, `div_tick`, `sclk_rise`, `sclk_fall` and `sclk_mon` are 0. The stored word is all zeros, which selects power-of-two mode with exponent 0.
- R2: With mode bit (bit 12) = 1, the linear field in bits 7:0 (value n) is used. `div_tick` then pulses every n+1 cycles, so the divided clock period is 2(n+1) module cycles.
- R3: With mode bit = 0 and exponent field in bits 11:8 (value e) ≥ 1, `div_tick` pulses every 2^(e-1) cycles, so the divided clock period is 2^e module cycles.
- R4: With mode bit = 0 and e = 0 (bypass), `div_tick` pulses every running cycle, and `sclk_rise` and `sclk_fall` are both high on every tick.
- R5: Outside bypass, each tick raises exactly one edge flag: `sclk_rise` when `sclk_mon` is low and `sclk_fall` when it is high.
- R6: `sclk_mon` inverts on the edge where `div_tick` is high and holds otherwise while running. The first tick after a restart is a rising one.
- R7: A write (`cfg_we` high at an edge) stores `cfg_wdata` and forces the divider idle for one cycle with `sclk_mon` at 0. If `enable` stays high, the first tick comes P+1 edges after the write edge, where P is the new tick period.
- R8: With `enable` low at an edge, `div_tick` and `sclk_mon` are 0 afterwards. The first edge with `enable` high starts the counter, and the first tick follows P edges after the idle-to-run transition, counting that edge.
- R9: The field not selected by the mode bit has no effect on the tick period.
- R10: The slowest settings work: linear n = 255 gives a tick every 256 cycles (divide by 512), and exponent 15 gives a tick every 16384 cycles (divide by 32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low holds the divider idle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 13 | Configuration word: {mode, exponent[3:0], linear[7:0]} |
| div_tick | output | 1 | Half-period tick for the shift engine |
| sclk_rise | output | 1 | Tick is a rising serial-clock edge |
| sclk_fall | output | 1 | Tick is a falling serial-clock edge |
| sclk_mon | output | 1 | Registered divided clock for observation |

## Verification
A wrong counter limit or a wrong field decode shows up as a tick gap that differs from the arithmetic period. It is visible at the second tick after a restart, so the bench measures the first tick and several gaps for every setting. A wrong divided-clock phase or edge flag shows on the very first tick, because that tick must always be a rising one. A missed restart shows one cycle after the write or the enable drop, as a nonzero divided clock or a premature tick.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CTRL_W = LIN_W + EXP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] word_q,
    output logic              lin_mode,
    output logic [LIN_W-1:0]  lin_div,
    output logic [EXP_W-1:0]  exp_div
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (we) begin
            word_q <= wdata;
        end
    end

    // mode bit sits above both divisor fields
    assign lin_mode = word_q[CTRL_W-1];
    assign exp_div  = word_q[LIN_W +: EXP_W];
    assign lin_div  = word_q[LIN_W-1:0];
endmodule

// File: rtl/sclk_limit_sel.sv
module sclk_limit_sel #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 14
) (
    input  logic             lin_mode,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] exp_div,
    output logic [CNT_W-1:0] limit,
    output logic             bypass
);
    always_comb begin
        bypass = !lin_mode && (exp_div == '0);
        if (lin_mode) begin
            limit = CNT_W'(lin_div);
        end else if (exp_div == '0) begin
            limit = '0;
        end else begin
            limit = (CNT_W'(1) << (exp_div - EXP_W'(1))) - CNT_W'(1);
        end
    end
endmodule

// File: rtl/sclk_div_fsm.sv
module sclk_div_fsm
    import sclk_div_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    input  logic             bypass,
    output logic             tick,
    output logic             rise,
    output logic             fall,
    output logic             sclk
);
    div_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic            hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable && !restart) state_d = ST_RUN;
            ST_RUN:  if (!enable || restart) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign hit = (state_q == ST_RUN) && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (state_d != ST_RUN || state_q != ST_RUN) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        tick = hit;
        rise = hit && (bypass || !sclk);
        fall = hit && (bypass || sclk);
    end
endmodule

// File: rtl/sclk_dual_divider.sv
module sclk_dual_divider #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CTRL_W  = LIN_W + EXP_W + 1,
    localparam int POW_MAX = (1 << EXP_W) - 2,
    localparam int CNT_W   = (LIN_W > POW_MAX) ? LIN_W : POW_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic              div_tick,
    output logic              sclk_rise,
    output logic              sclk_fall,
    output logic              sclk_mon
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              lin_mode;
    logic [LIN_W-1:0]  lin_div;
    logic [EXP_W-1:0]  exp_div;
    logic [CNT_W-1:0]  limit;
    logic              bypass;

    sclk_cfg_reg #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .word_q(ctrl_q), .lin_mode(lin_mode), .lin_div(lin_div), .exp_div(exp_div)
    );

    sclk_limit_sel #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_lim (
        .lin_mode(lin_mode), .lin_div(lin_div), .exp_div(exp_div),
        .limit(limit), .bypass(bypass)
    );

    sclk_div_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(cfg_we),
        .limit(limit), .bypass(bypass),
        .tick(div_tick), .rise(sclk_rise), .fall(sclk_fall), .sclk(sclk_mon)
    );
endmodule

// File: rtl/sclk_dual_divider_chk.sv
module sclk_dual_divider_chk #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CTRL_W = LIN_W + EXP_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              cfg_we,
    input logic              div_tick,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              sclk_mon,
    input logic [CTRL_W-1:0] ctrl_q
);
    int   exp_gap;
    int   since;
    logic armed;
    logic in_bypass;

    always_comb begin
        in_bypass = !ctrl_q[CTRL_W-1] && (ctrl_q[LIN_W +: EXP_W] == '0);
        if (ctrl_q[CTRL_W-1]) exp_gap = int'(ctrl_q[LIN_W-1:0]);
        else if (in_bypass) exp_gap = 0;
        else exp_gap = (1 << (int'(ctrl_q[LIN_W +: EXP_W]) - 1)) - 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= 0;
            armed <= 1'b0;
        end else begin
            since <= div_tick ? 0 : since + 1;
            if (cfg_we || !enable) armed <= 1'b0;
            else if (div_tick) armed <= 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && armed) |-> (since == exp_gap)); // R2 R3

    AST_BYPASS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && in_bypass) |-> (sclk_rise && sclk_fall)); // R4

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && !in_bypass) |-> $countones({sclk_rise, sclk_fall}) == 1 && (sclk_rise == !sclk_mon)); // R5

    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && enable && !cfg_we) |=> (sclk_mon != $past(sclk_mon))); // R6

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_tick && enable && !cfg_we) |=> $stable(sclk_mon)); // R6

    AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!div_tick && !sclk_mon)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!div_tick && !sclk_mon)); // R8
endmodule

bind sclk_dual_divider sclk_dual_divider_chk #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .div_tick(div_tick), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sclk_mon(sclk_mon), .ctrl_q(ctrl_q)
);

// File: tb/sim_sclk_dual_divider.sv
`timescale 1ns/1ps
module sim_sclk_dual_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_wdata = '0;
    logic        div_tick, sclk_rise, sclk_fall, sclk_mon;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    sclk_dual_divider u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .div_tick(div_tick), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sclk_mon(sclk_mon)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ends at the negedge after the write edge
    task automatic write_cfg(bit mode, int e, int n);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {mode, 4'(e), 8'(n)};
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called at the negedge after the reference edge (one edge counted)
    task automatic measure(int p, int first, int nper, bit byp, string req);
        int c = 1;
        chk(sclk_mon == 1'b0, {req, " R7 R8 start level"}, int'(sclk_mon), 0);
        while (!div_tick && c < 40000) begin
            @(posedge clk); @(negedge clk); c++;
        end
        chk(c == first, {req, " first tick"}, c, first);
        for (int k = 0; k <= nper; k++) begin
            chk(sclk_mon == 1'(k % 2), {req, " R6 sclk level"}, int'(sclk_mon), k % 2);
            if (byp) begin
                chk(sclk_rise && sclk_fall, {req, " R4 both flags"}, {sclk_rise, sclk_fall}, 3);
            end else begin
                chk({sclk_rise, sclk_fall} == ((k % 2 == 0) ? 2'b10 : 2'b01),
                    {req, " R5 edge flag"}, {sclk_rise, sclk_fall}, (k % 2 == 0) ? 2 : 1);
            end
            if (k == nper) break;
            c = 0;
            do begin
                @(posedge clk); @(negedge clk); c++;
            end while (!div_tick && c < 40000);
            chk(c == p, {req, " tick gap"}, c, p);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({div_tick, sclk_rise, sclk_fall, sclk_mon} == 4'b0, "R1 outputs in reset",
            {div_tick, sclk_rise, sclk_fall, sclk_mon}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!div_tick && !sclk_mon, "R1 idle after reset", {div_tick, sclk_mon}, 0);
        // reset word selects bypass
        enable = 1'b1;
        @(posedge clk); @(negedge clk);
        measure(1, 1, 4, 1'b1, "R1 R4 reset bypass");

        // linear sweep, exponent field carries noise (R9)
        for (int n = 0; n < 24; n++) begin
            write_cfg(1'b1, n % 16, n);
            measure(n + 1, n + 2, 3, 1'b0, "R2 R9 linear");
        end
        for (int n = 250; n < 256; n++) begin
            write_cfg(1'b1, 15 - (n % 16), n);
            measure(n + 1, n + 2, 2, 1'b0, (n == 255) ? "R10 R2 slowest linear" : "R2 linear");
        end

        // power-of-two sweep, linear field carries noise (R9)
        for (int e = 0; e < 16; e++) begin
            int p;
            p = (e == 0) ? 1 : (1 << (e - 1));
            write_cfg(1'b0, e, 8'hA5 ^ e);
            measure(p, p + 1, (e >= 13) ? 1 : 3, e == 0,
                    (e == 15) ? "R10 R3 slowest power" : (e == 0 ? "R4 bypass" : "R3 R9 power"));
        end

        // enable drop and restart (R8)
        write_cfg(1'b1, 0, 6);
        repeat (17) @(negedge clk);
        enable = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!div_tick && !sclk_mon, "R8 idle after enable low", {div_tick, sclk_mon}, 0);
        repeat (9) begin
            @(negedge clk);
            chk(!div_tick, "R8 no tick while disabled", int'(div_tick), 0);
        end
        enable = 1'b1;
        @(posedge clk); @(negedge clk);
        measure(7, 7, 3, 1'b0, "R8 enable restart");

        // write mid-period while running (R7)
        repeat (3) @(negedge clk);
        write_cfg(1'b0, 3, 0);
        chk(!div_tick, "R7 no tick after write", int'(div_tick), 0);
        measure(4, 5, 3, 1'b0, "R7 R3 write restart");

        // write while disabled latches the word (R7)
        enable = 1'b0;
        write_cfg(1'b1, 0, 2);
        @(negedge clk);
        enable = 1'b1;
        @(posedge clk); @(negedge clk);
        measure(3, 3, 2, 1'b0, "R7 R8 write while idle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule